// File: doc/BRIEF.md
# Block-Threshold Receive FIFO Controller

This block buffers the bytes of incoming frames between a byte-wide frame receiver and a host processor, and hands them to the host one block at a time. The block size is 16 or 32 bytes. A block is offered to the host when a block's worth of an unfinished frame has built up, which raises the pool-full flag, or when a frame ends, which raises the message-end flag. A frame that finds the store full is lost, and the loss flag is raised. Only one block is offered at a time. The host reads its bytes through a read port and then gives it back with a release command. Until that release, no further block is offered.

A 12-bit frame length counter grows by each offered block's length. When a frame ends, the counter's low bits hold the length of the last block and its upper bits hold the count of full blocks. A sticky wrap bit marks frames longer than 4095 bytes. A receiver reset command empties the store and clears the counter, and it takes in a new block-size selection. It leaves the event flags alone. The flags clear only when the host reads the status.

Top module: `rx_block_fifo`

## Requirements
- R1: After reset, `stat` is 000, `irq` is 0, `frame_cnt` is 0, `cnt_ovf` is 0, and the block size is 16.
- R2: The block size is taken from `cfg_blk32` when `cmd_rreset` is sampled (0 selects 16 bytes, 1 selects 32 bytes). `cfg_blk32` has no effect at any other time.
- R3: An unfinished frame may accumulate a block-size worth of bytes while no block is held. In that case the block is offered one cycle after its last byte is stored. This sets `stat[0]` (pool-full) and the block becomes the held block.
- R4: A byte sampled with `rx_eof` ends the frame. The pending 1 to block-size bytes form a block, which is offered as in R3, except that `stat[1]` (message-end) is set.
- R5: While a block is held, no other block is offered and no pool-full or message-end flag is raised. After `cmd_release`, the oldest waiting block is offered on the following cycle.
- R6: `rd_data` shows the held block's byte at the read position, in arrival order, starting at its first byte. Each `rd_en` advances the position by one. `rd_en` has no effect when no block is held or when the whole block has been read.
- R7: `cmd_release` frees the held block's storage. When that block ended a frame, it also sets `frame_cnt` and `cnt_ovf` to 0. `cmd_release` has no effect when no block is held.
- R8: Each offer adds the block length to `frame_cnt`. At message-end, the low log2(block size) bits hold the last block length modulo the block size, where 0 means a full block. The bits above them hold the number of full blocks.
- R9: `frame_cnt` wraps modulo 4096. `cnt_ovf` becomes 1 when an offer carries the count past 4095. It stays 1 until it is cleared as in R7 or R12.
- R10: The store holds 64 bytes, counting the held block. A byte can arrive while all 64 bytes are occupied. In that case `stat[2]` (loss) is set one cycle later. The current frame's bytes since its last block boundary are discarded, and all further bytes up to and including its end byte are ignored.
- R11: `rx_abort` discards the current frame's bytes since its last block boundary and raises no flag. A byte sampled with it is ignored.
- R12: `cmd_rreset` empties the store, drops the held block and sets `frame_cnt` and `cnt_ovf` to 0. It leaves `stat` unchanged.
- R13: A cycle with `stat_rd` clears all of `stat`, but a flag raised in that same cycle survives. `irq` is 1 exactly when some bit of `stat` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_blk32 | input | 1 | Block size selection, taken in at receiver reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Marks the strobed byte as the last byte of its frame |
| rx_abort | input | 1 | Cancels the frame being received |
| rd_en | input | 1 | Advance the host read position |
| rd_data | output | 8 | Byte of the held block at the read position |
| cmd_release | input | 1 | Give back the held block |
| cmd_rreset | input | 1 | Receiver reset |
| stat_rd | input | 1 | Status read, clears all flags |
| stat | output | 3 | Flags: bit 0 pool-full, bit 1 message-end, bit 2 loss |
| irq | output | 1 | Interrupt request |
| frame_cnt | output | 12 | Frame length counter |
| cnt_ovf | output | 1 | Sticky counter wrap bit |

## Verification
The assertions check, on every cycle, the structural invariants. Occupancy never exceeds 64 bytes, and the pending segment stays shorter than a block. The held block keeps its length and its read position stays inside it until it is released. Ignored bytes after a loss do not move the write pointer. Flags persist until a status read, and a receiver reset leaves the store empty. Only the bench's scenarios can show the rest of the behaviour. That covers the block boundaries as the host sees them, and the counter encoding of last-block length and full-block count for both block sizes. It also covers the data order through the read port, the discarded tail of a lost or aborted frame, and the counter wrap on a 4100-byte frame.

// File: rtl/rxbf_pkg.sv
package rxbf_pkg;
  localparam int unsigned FLAG_W    = 3;
  localparam int unsigned FLAG_POOL = 0;
  localparam int unsigned FLAG_END  = 1;
  localparam int unsigned FLAG_LOSS = 2;

  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/rxbf_desc_fifo.sv
// Queue of completed-block descriptors waiting to be offered to the host.
module rxbf_desc_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         avail
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          we;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    we    = 1'b0;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) begin
        we   = 1'b1;
        wp_d = wp_q + 1'b1;
      end
      if (pop) rp_d = rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) slot[wp_q] <= din;
  end

  assign dout  = slot[rp_q];
  assign avail = (cnt_q != '0);

  // R10
  desc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> (cnt_q != PW'(DEPTH)));
  // R5
  desc_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> avail);
endmodule

// File: rtl/rxbf_store.sv
// Byte store and receive side: segmenting into blocks, abort and loss handling.
module rxbf_store #(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned SMALL_BLK = 16,
  parameter int unsigned LARGE_BLK = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rreset,
  input  logic                         cfg_large,
  input  logic                         rx_valid,
  input  logic [7:0]                   rx_data,
  input  logic                         rx_eof,
  input  logic                         rx_abort,
  input  logic [$clog2(DEPTH):0]       rel_ptr,
  input  logic [$clog2(DEPTH)-1:0]     rd_addr,
  output logic [7:0]                   rd_data,
  output logic                         push,
  output logic [$clog2(LARGE_BLK):0]   push_len,
  output logic                         push_last,
  output logic                         loss_evt,
  output logic [$clog2(DEPTH):0]       used
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam int unsigned LW = $clog2(LARGE_BLK) + 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d;
  logic [LW-1:0] seg_q, seg_d;
  logic          drop_q, drop_d;
  logic          large_q, large_d;
  logic          mem_we;
  logic [LW-1:0] bs, seg_inc;
  logic [PW-1:0] rewind;
  logic          full;

  assign bs      = large_q ? LW'(LARGE_BLK) : LW'(SMALL_BLK);
  assign seg_inc = seg_q + 1'b1;
  assign used    = wr_q - rel_ptr;
  assign full    = (used == PW'(DEPTH));
  assign rewind  = wr_q - PW'(seg_q);

  always_comb begin
    wr_d      = wr_q;
    seg_d     = seg_q;
    drop_d    = drop_q;
    large_d   = large_q;
    mem_we    = 1'b0;
    push      = 1'b0;
    push_len  = seg_inc;
    push_last = rx_eof;
    loss_evt  = 1'b0;
    if (rreset) begin
      wr_d    = '0;
      seg_d   = '0;
      drop_d  = 1'b0;
      large_d = cfg_large;
    end else if (rx_abort) begin
      if (!drop_q) wr_d = rewind;
      seg_d  = '0;
      drop_d = 1'b0;
    end else if (rx_valid) begin
      if (drop_q) begin
        if (rx_eof) drop_d = 1'b0;
      end else if (full) begin
        wr_d     = rewind;
        seg_d    = '0;
        loss_evt = 1'b1;
        drop_d   = !rx_eof;
      end else begin
        mem_we = 1'b1;
        wr_d   = wr_q + 1'b1;
        if (rx_eof || (seg_inc == bs)) begin
          push  = 1'b1;
          seg_d = '0;
        end else begin
          seg_d = seg_inc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      seg_q   <= '0;
      drop_q  <= 1'b0;
      large_q <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      seg_q   <= seg_d;
      drop_q  <= drop_d;
      large_q <= large_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_q[AW-1:0]] <= rx_data;
  end

  assign rd_data = mem[rd_addr];

  // R10
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));
  // R3
  segment_below_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q < bs);
  // R10
  dropped_byte_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && rx_valid && !rx_eof && !rx_abort && !rreset) |=> (wr_q == $past(wr_q)));
endmodule

// File: rtl/rxbf_host.sv
// Host side: block offer, read position, release, frame counter and flags.
module rxbf_host
  import rxbf_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned LARGE_BLK = 32,
  parameter int unsigned CNT_W     = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rreset,
  input  logic                       head_avail,
  input  logic [$clog2(LARGE_BLK):0] head_len,
  input  logic                       head_last,
  output logic                       head_pop,
  input  logic                       rd_en,
  input  logic                       release_cmd,
  input  logic                       stat_rd,
  input  logic                       loss_evt,
  output logic [$clog2(DEPTH):0]     rel_ptr,
  output logic [$clog2(DEPTH):0]     rd_ptr,
  output logic                       held,
  output flags_t                     flags,
  output logic [CNT_W-1:0]           frame_cnt,
  output logic                       cnt_ovf
);
  localparam int unsigned PW = $clog2(DEPTH) + 1;
  localparam int unsigned LW = $clog2(LARGE_BLK) + 1;

  logic          held_q, held_d, last_q, last_d, ovf_q, ovf_d;
  logic [LW-1:0] len_q, len_d;
  logic [PW-1:0] rel_q, rel_d, rdp_q, rdp_d, blk_end;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;
  flags_t        flags_q, flags_d, ev;

  assign blk_end = rel_q + PW'(len_q);
  assign sum     = {1'b0, cnt_q} + (CNT_W+1)'(head_len);

  always_comb begin
    held_d   = held_q;
    len_d    = len_q;
    last_d   = last_q;
    rel_d    = rel_q;
    rdp_d    = rdp_q;
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    head_pop = 1'b0;
    ev       = '0;
    if (rreset) begin
      held_d = 1'b0;
      rel_d  = '0;
      rdp_d  = '0;
      cnt_d  = '0;
      ovf_d  = 1'b0;
    end else if (held_q) begin
      if (rd_en && (rdp_q != blk_end)) rdp_d = rdp_q + 1'b1;
      if (release_cmd) begin
        rel_d  = blk_end;
        held_d = 1'b0;
        if (last_q) begin
          cnt_d = '0;
          ovf_d = 1'b0;
        end
      end
    end else if (head_avail) begin
      head_pop = 1'b1;
      held_d   = 1'b1;
      len_d    = head_len;
      last_d   = head_last;
      rdp_d    = rel_q;
      cnt_d    = sum[CNT_W-1:0];
      ovf_d    = ovf_q | sum[CNT_W];
      if (head_last) ev[FLAG_END] = 1'b1;
      else           ev[FLAG_POOL] = 1'b1;
    end
    if (loss_evt) ev[FLAG_LOSS] = 1'b1;
    flags_d = (flags_q & ~{FLAG_W{stat_rd}}) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      len_q   <= '0;
      last_q  <= 1'b0;
      rel_q   <= '0;
      rdp_q   <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      held_q  <= held_d;
      len_q   <= len_d;
      last_q  <= last_d;
      rel_q   <= rel_d;
      rdp_q   <= rdp_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      flags_q <= flags_d;
    end
  end

  assign rel_ptr   = rel_q;
  assign rd_ptr    = rdp_q;
  assign held      = held_q;
  assign flags     = flags_q;
  assign frame_cnt = cnt_q;
  assign cnt_ovf   = ovf_q;

  // R6
  read_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> ((rdp_q - rel_q) <= PW'(len_q)));
  // R4
  held_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> (len_q != '0));
  // R5
  hold_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !rreset && !release_cmd) |=> (held_q && $stable(len_q) && $stable(rel_q)));
  // R9
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !rreset && !(held_q && release_cmd && last_q)) |=> ovf_q);
  // R13
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/rx_block_fifo.sv
module rx_block_fifo
  import rxbf_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned SMALL_BLK = 16,
  parameter int unsigned LARGE_BLK = 32,
  parameter int unsigned CNT_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_blk32,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof,
  input  logic              rx_abort,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic              cmd_release,
  input  logic              cmd_rreset,
  input  logic              stat_rd,
  output logic [FLAG_W-1:0] stat,
  output logic              irq,
  output logic [CNT_W-1:0]  frame_cnt,
  output logic              cnt_ovf
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam int unsigned LW = $clog2(LARGE_BLK) + 1;
  localparam int unsigned DW = LW + 1;

  logic          rst_meta, rst_sync_n;
  logic [PW-1:0] rel_ptr, rd_ptr, used;
  logic          push, push_last, loss_evt, head_avail, head_pop, held;
  logic [LW-1:0] push_len;
  logic [DW-1:0] head;
  flags_t        flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  rxbf_store #(
    .DEPTH(DEPTH), .SMALL_BLK(SMALL_BLK), .LARGE_BLK(LARGE_BLK)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n), .rreset(cmd_rreset), .cfg_large(cfg_blk32),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_abort(rx_abort),
    .rel_ptr(rel_ptr), .rd_addr(rd_ptr[AW-1:0]), .rd_data(rd_data),
    .push(push), .push_len(push_len), .push_last(push_last),
    .loss_evt(loss_evt), .used(used)
  );

  rxbf_desc_fifo #(.DEPTH(DEPTH), .W(DW)) u_desc (
    .clk(clk), .rst_n(rst_sync_n), .clr(cmd_rreset),
    .push(push), .din({push_len, push_last}),
    .pop(head_pop), .dout(head), .avail(head_avail)
  );

  rxbf_host #(.DEPTH(DEPTH), .LARGE_BLK(LARGE_BLK), .CNT_W(CNT_W)) u_host (
    .clk(clk), .rst_n(rst_sync_n), .rreset(cmd_rreset),
    .head_avail(head_avail), .head_len(head[DW-1:1]), .head_last(head[0]),
    .head_pop(head_pop), .rd_en(rd_en), .release_cmd(cmd_release),
    .stat_rd(stat_rd), .loss_evt(loss_evt), .rel_ptr(rel_ptr), .rd_ptr(rd_ptr),
    .held(held), .flags(flags), .frame_cnt(frame_cnt), .cnt_ovf(cnt_ovf)
  );

  assign stat = flags;
  assign irq  = |flags;

  // R12
  rreset_empty_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_rreset |=> ((used == '0) && !held && (frame_cnt == '0)));
endmodule

// File: tb/tb_rx_block_fifo.sv
`timescale 1ns/1ps
module tb_rx_block_fifo;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n, cfg_blk32, rx_valid, rx_eof, rx_abort, rd_en;
  logic       cmd_release, cmd_rreset, stat_rd, irq, cnt_ovf;
  logic [7:0] rx_data, rd_data;
  logic [2:0] stat;
  logic [11:0] frame_cnt;

  always #2.5 clk = ~clk;

  rx_block_fifo dut (
    .clk(clk), .rst_n(rst_n), .cfg_blk32(cfg_blk32), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_abort(rx_abort), .rd_en(rd_en),
    .rd_data(rd_data), .cmd_release(cmd_release), .cmd_rreset(cmd_rreset),
    .stat_rd(stat_rd), .stat(stat), .irq(irq), .frame_cnt(frame_cnt),
    .cnt_ovf(cnt_ovf)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] seed = 8'h10;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_q[$];
  int  m_dlen[$];
  bit  m_dend[$];
  int  m_bs, m_hlen, m_roff, m_seg, m_cnt;
  bit  m_held, m_hend, m_drop, m_cov;
  bit [2:0] m_stat;

  always @(posedge clk) begin : model
    int used;
    bit [2:0] ev;
    ev = 3'b000;
    if (!rst_n) begin
      m_q.delete(); m_dlen.delete(); m_dend.delete();
      m_bs = 16; m_held = 0; m_hlen = 0; m_hend = 0; m_roff = 0;
      m_seg = 0; m_drop = 0; m_cnt = 0; m_cov = 0; m_stat = 3'b000;
    end else begin
      used = m_q.size();
      if (cmd_rreset) begin
        m_q.delete(); m_dlen.delete(); m_dend.delete();
        m_held = 0; m_seg = 0; m_drop = 0; m_cnt = 0; m_cov = 0;
        m_bs = cfg_blk32 ? 32 : 16;
      end else begin
        if (m_held) begin
          if (rd_en && m_roff < m_hlen) m_roff++;
          if (cmd_release) begin
            repeat (m_hlen) void'(m_q.pop_front());
            if (m_hend) begin m_cnt = 0; m_cov = 0; end
            m_held = 0;
          end
        end else if (m_dlen.size() > 0) begin
          m_hlen = m_dlen.pop_front();
          m_hend = m_dend.pop_front();
          m_roff = 0; m_held = 1;
          if (m_cnt + m_hlen > 4095) m_cov = 1;
          m_cnt = (m_cnt + m_hlen) % 4096;
          if (m_hend) ev[1] = 1'b1; else ev[0] = 1'b1;
        end
        if (rx_abort) begin
          if (!m_drop) repeat (m_seg) void'(m_q.pop_back());
          m_seg = 0; m_drop = 0;
        end else if (rx_valid) begin
          if (m_drop) begin
            if (rx_eof) m_drop = 0;
          end else if (used == DEPTH) begin
            repeat (m_seg) void'(m_q.pop_back());
            m_seg = 0; ev[2] = 1'b1; m_drop = !rx_eof;
          end else begin
            m_q.push_back(rx_data);
            m_seg++;
            if (rx_eof || m_seg == m_bs) begin
              m_dlen.push_back(m_seg); m_dend.push_back(rx_eof); m_seg = 0;
            end
          end
        end
      end
      m_stat = (m_stat & ~{3{stat_rd}}) | ev;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R3",  "stat[0]", stat[0], m_stat[0]);
      chk("R4",  "stat[1]", stat[1], m_stat[1]);
      chk("R10", "stat[2]", stat[2], m_stat[2]);
      chk("R13", "irq", irq, |m_stat);
      chk("R8",  "frame_cnt", frame_cnt, m_cnt);
      chk("R9",  "cnt_ovf", cnt_ovf, m_cov);
      if (m_held && m_roff < m_hlen) chk("R6", "rd_data", rd_data, m_q[m_roff]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(int n, int gap, bit end_abort);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = seed; seed = seed + 8'd7;
      rx_eof = (i == n - 1) && !end_abort;
      if (gap > 0) begin
        @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    if (end_abort) begin
      rx_abort = 1'b1; @(negedge clk); rx_abort = 1'b0;
    end
  endtask

  task automatic serve(output logic [2:0] s, output int c, output logic o);
    do @(negedge clk); while (!irq);
    s = stat; c = frame_cnt; o = cnt_ovf;
    stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0; rd_en = 1'b1;
    repeat (32) @(negedge clk);
    rd_en = 1'b0; cmd_release = 1'b1;
    @(negedge clk); cmd_release = 1'b0;
  endtask

  task automatic pulse_stat_rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic pulse_release();
    cmd_release = 1'b1; @(negedge clk); cmd_release = 1'b0;
  endtask

  task automatic pulse_rreset();
    cmd_rreset = 1'b1; @(negedge clk); cmd_rreset = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin : main
    logic [2:0] s;
    int c;
    logic o;
    logic [7:0] first;
    rst_n = 1'b0; cfg_blk32 = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    rx_eof = 1'b0; rx_abort = 1'b0; rd_en = 1'b0; cmd_release = 1'b0;
    cmd_rreset = 1'b0; stat_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1", "stat", stat, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "frame_cnt", frame_cnt, 0);
    chk("R1", "cnt_ovf", cnt_ovf, 0);

    // R6 read with nothing held has no effect; R7 release ignored
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    pulse_release();

    // short frame: message-end, read order, status read, release
    first = seed;
    send(5, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R4", "short frame stat", stat, 3'b010);
    chk("R8", "short frame cnt", frame_cnt, 5);
    chk("R13", "irq with flag", irq, 1);
    chk("R6", "first byte", rd_data, first);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R6", "second byte", rd_data, first + 8'd7);
    pulse_stat_rd();
    chk("R13", "stat after read", stat, 0);
    chk("R13", "irq after read", irq, 0);
    pulse_release();
    @(negedge clk);
    chk("R7", "cnt cleared by end release", frame_cnt, 0);

    // long frame of 40 bytes, block 16
    fork
      send(40, 1, 1'b0);
      begin
        serve(s, c, o);
        chk("R3", "block1 stat", s, 3'b001); chk("R8", "block1 cnt", c, 16);
        serve(s, c, o);
        chk("R3", "block2 stat", s, 3'b001); chk("R8", "block2 cnt", c, 32);
        serve(s, c, o);
        chk("R4", "block3 stat", s, 3'b010); chk("R8", "block3 cnt", c, 40);
        chk("R8", "last block len bits", c % 16, 8);
        chk("R8", "full block bits", c / 16, 2);
      end
    join
    @(negedge clk);
    chk("R7", "cnt after long frame", frame_cnt, 0);

    // 32-byte frame: last block full, low bits 0
    fork
      send(32, 1, 1'b0);
      begin
        serve(s, c, o);
        chk("R3", "32b block1", s, 3'b001);
        serve(s, c, o);
        chk("R4", "32b block2", s, 3'b010);
        chk("R8", "32b full last block", c % 16, 0);
        chk("R8", "32b block count", c / 16, 2);
      end
    join

    // R5 no event while held; next block after release
    send(3, 0, 1'b0);
    send(4, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5", "first frame offered", stat, 3'b010);
    chk("R5", "first frame cnt", frame_cnt, 3);
    pulse_stat_rd();
    repeat (10) @(negedge clk);
    chk("R5", "no event while held", stat, 0);
    pulse_release();
    @(negedge clk);
    chk("R5", "second frame offered after release", stat, 3'b010);
    chk("R5", "second frame cnt", frame_cnt, 4);
    serve(s, c, o);

    // R11 abort
    send(10, 0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R11", "no flag on abort", stat, 0);
    chk("R11", "cnt after abort", frame_cnt, 0);
    fork
      send(3, 0, 1'b0);
      serve(s, c, o);
    join
    chk("R11", "aborted bytes not counted", c, 3);

    // R10 overflow: 80-byte burst with no service
    send(80, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10", "loss and pool flags", stat, 3'b101);
    serve(s, c, o);
    chk("R10", "first served stat", s, 3'b101);
    for (int k = 0; k < 3; k++) begin
      serve(s, c, o);
      chk("R3", "stored block after loss", s, 3'b001);
    end
    repeat (5) @(negedge clk);
    chk("R10", "dropped tail never offered", irq, 0);
    chk("R10", "cnt of kept blocks", frame_cnt, 64);
    pulse_rreset();
    chk("R12", "cnt cleared by rreset", frame_cnt, 0);

    // R12 flags untouched by receiver reset
    send(2, 0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R12", "flag before rreset", stat, 3'b010);
    pulse_rreset();
    chk("R12", "flag kept across rreset", stat, 3'b010);
    chk("R12", "cnt zero after rreset", frame_cnt, 0);
    repeat (3) @(negedge clk);
    chk("R12", "dropped block not offered", frame_cnt, 0);
    pulse_stat_rd();

    // R2 block size 32 selected at receiver reset
    cfg_blk32 = 1'b1;
    pulse_rreset();
    fork
      send(40, 1, 1'b0);
      begin
        serve(s, c, o);
        chk("R2", "32-byte block stat", s, 3'b001);
        chk("R2", "32-byte block cnt", c, 32);
        serve(s, c, o);
        chk("R4", "end with 32 block", s, 3'b010);
        chk("R8", "last len bits at 32", c % 32, 8);
        chk("R8", "full blocks at 32", c / 32, 1);
      end
    join
    cfg_blk32 = 1'b0;
    send(20, 1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2", "size held without rreset", frame_cnt, 20);
    serve(s, c, o);

    // R9 wrap on 4100-byte frame
    fork
      send(4100, 1, 1'b0);
      begin
        do serve(s, c, o); while (!s[1]);
        chk("R9", "wrapped count", c, 4);
        chk("R9", "wrap bit", o, 1);
      end
    join
    @(negedge clk);
    chk("R7", "wrap bit cleared by release", cnt_ovf, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule